// File: doc/BRIEF.md
# DVFS Load-Level Configuration Selector

This block decides which clock source index and which integer divider the CPU clock path uses. When dynamic scaling is on, the choice comes from one of four performance load levels, each with its own divider, source index and alternate-clock flag held in two 32-bit level registers. The current level is a 2-bit register. When dynamic scaling is off, a static source index and divider held in a mode register drive the outputs.

A rate request supplies a target divider. The block compares that divider against the four levels in a fixed four-cycle scan, from level 0 up to level 3. It moves the current level to the first level that matches and then pulses a done strobe. If no level matches, or dynamic scaling is off, the done strobe comes with an error pulse and the level does not change. A simple write port loads the level registers and the mode register.

Top module: `dvfs_level_sel`

## Requirements
- R1: After reset, the current level is 0, dynamic scaling is off, busy, done and error are low, and the outputs show source 0, divider 0 and alternate flag 0.
- R2: While dynamic scaling is off, out_src equals mode bits [1:0], out_div equals mode bits [4:2] and out_alt is 0. The mode register is at write address 2, and its bit 31 is the scaling enable.
- R3: While dynamic scaling is on, the outputs show the configuration of the current level. Levels 0 and 1 come from the register at address 0, and levels 2 and 3 from the register at address 1. Level 0 and level 2 use bits [31:16] of their register, and level 1 and level 3 use bits [15:0].
- R4: Inside a 16-bit half, the divider is bits [15:13], the alternate flag is bit 11 and the source index is bits [10:9]. Bits 12 and [8:0] of a half have no effect.
- R5: A request made while idle raises busy on the next clock edge. Busy stays high for exactly four cycles. Done is high for exactly one cycle, the cycle after busy falls.
- R6: A successful request sets the current level to the lowest-numbered level whose divider equals the requested divider.
- R7: If no level matches, error is high together with done for one cycle and the current level does not change. Outside a successful completion, the current level never changes.
- R8: A request that completes while dynamic scaling is off is rejected with error, even if some level's divider matches, and the current level does not change.
- R9: A request made while busy is ignored. The scan in progress keeps its captured divider, and no second scan follows.
- R10: A write to address 3 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Write address: 0 levels 0/1, 1 levels 2/3, 2 mode |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Rate request, taken when idle |
| req_div | input | 3 | Requested divider |
| req_busy | output | 1 | Scan in progress |
| req_done | output | 1 | One-cycle completion strobe |
| req_err | output | 1 | One-cycle rejection strobe, with done |
| cur_level | output | 2 | Current load level |
| dyn_on | output | 1 | Dynamic scaling enabled |
| out_src | output | 2 | Selected clock source index |
| out_div | output | 3 | Selected divider |
| out_alt | output | 1 | Alternate clock select of current level |

## Verification
The assertions check the following on every cycle: the four-cycle busy window, that done is a one-cycle pulse that follows busy, that error only comes with done, that the level is frozen outside a successful completion, and that a completion while scaling is disabled is always rejected. After each successful completion they also check that the output divider equals the captured request. Other behaviour only shows in the bench's scenarios. This covers the first-match ordering when dividers repeat, the mapping from each level to its register and half-word, the static fallback values, the inertness of the junk bits and of address 3, and the dropping of requests made while busy. These are swept over several level tables and over all eight divider values.

// File: rtl/dvfs_sel_pkg.sv
package dvfs_sel_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 2;
  localparam int HALF_W     = REG_W / 2;
  localparam int NUM_LVL    = 4;
  localparam int LVL_W      = $clog2(NUM_LVL);
  localparam int NUM_PAIRS  = NUM_LVL / 2;
  localparam int DIV_W      = 3;
  localparam int SRC_W      = 2;
  localparam int DIV_LSB    = 13;
  localparam int ALT_BIT    = 11;
  localparam int SRC_LSB    = 9;
  localparam int EN_BIT     = 31;
  localparam int ST_SRC_LSB = 0;
  localparam int ST_DIV_LSB = 2;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 2'd2;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             alt;
    logic [SRC_W-1:0] src;
  } lvl_cfg_t;

  typedef enum logic {S_IDLE, S_SCAN} scan_st_t;

  function automatic lvl_cfg_t half_decode(input logic [HALF_W-1:0] h);
    lvl_cfg_t r;
    r.div = h[DIV_LSB +: DIV_W];
    r.alt = h[ALT_BIT];
    r.src = h[SRC_LSB +: SRC_W];
    return r;
  endfunction
endpackage

// File: rtl/dvfs_rst_sync.sv
module dvfs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dvfs_cfg_regs.sv
module dvfs_cfg_regs
  import dvfs_sel_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [REG_W-1:0]                  wdata,
  output lvl_cfg_t [NUM_LVL-1:0]            cfg,
  output logic                              en,
  output logic [SRC_W-1:0]                  st_src,
  output logic [DIV_W-1:0]                  st_div
);
  // bits of the write word that no register keeps
  logic unused_wbits;
  assign unused_wbits = ^{wdata[28], wdata[24:16], wdata[12], wdata[8:5]};

  // level pairs: each address holds two levels, even level in the upper half
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic pair_we;
    assign pair_we = we && (addr == ADDR_W'(p));
    for (genvar h = 0; h < 2; h++) begin : g_half
      lvl_cfg_t lvl_d, lvl_q;
      always_comb begin
        lvl_d = lvl_q;
        if (pair_we) lvl_d = half_decode(wdata[(1-h)*HALF_W +: HALF_W]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
      end
      assign cfg[2*p+h] = lvl_q;
    end
  end

  // mode register
  logic             mode_we;
  logic             en_d, en_q;
  logic [SRC_W-1:0] src_d, src_q;
  logic [DIV_W-1:0] div_d, div_q;

  assign mode_we = we && (addr == MODE_ADDR);

  always_comb begin
    en_d  = en_q;
    src_d = src_q;
    div_d = div_q;
    if (mode_we) begin
      en_d  = wdata[EN_BIT];
      src_d = wdata[ST_SRC_LSB +: SRC_W];
      div_d = wdata[ST_DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      src_q <= '0;
      div_q <= '0;
    end else begin
      en_q  <= en_d;
      src_q <= src_d;
      div_q <= div_d;
    end
  end

  assign en     = en_q;
  assign st_src = src_q;
  assign st_div = div_q;
endmodule

// File: rtl/dvfs_level_scan.sv
module dvfs_level_scan
  import dvfs_sel_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  lvl_cfg_t [NUM_LVL-1:0] cfg,
  input  logic                   en,
  input  logic                   req_valid,
  input  logic [DIV_W-1:0]       req_div,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [LVL_W-1:0]       level,
  output logic [DIV_W-1:0]       req_q
);
  localparam logic [LVL_W-1:0] LAST_IDX = LVL_W'(NUM_LVL - 1);

  scan_st_t         st_d, st_q;
  logic [LVL_W-1:0] idx_d, idx_q;
  logic             hit_d, hit_q;
  logic [LVL_W-1:0] hit_lvl_d, hit_lvl_q;
  logic [DIV_W-1:0] div_d, div_q;
  logic [LVL_W-1:0] lvl_d, lvl_q;
  logic             done_d, done_q;
  logic             err_d, err_q;
  logic             cur_hit;

  assign cur_hit = (cfg[idx_q].div == div_q);

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    hit_d     = hit_q;
    hit_lvl_d = hit_lvl_q;
    div_d     = div_q;
    lvl_d     = lvl_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          st_d      = S_SCAN;
          idx_d     = '0;
          hit_d     = 1'b0;
          hit_lvl_d = '0;
          div_d     = req_div;
        end
      end
      S_SCAN: begin
        if (!hit_q && cur_hit) begin
          hit_d     = 1'b1;
          hit_lvl_d = idx_q;
        end
        if (idx_q == LAST_IDX) begin
          st_d   = S_IDLE;
          done_d = 1'b1;
          if (en && (hit_q || cur_hit)) lvl_d = hit_q ? hit_lvl_q : idx_q;
          else                          err_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      idx_q     <= '0;
      hit_q     <= 1'b0;
      hit_lvl_q <= '0;
      div_q     <= '0;
      lvl_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      idx_q     <= idx_d;
      hit_q     <= hit_d;
      hit_lvl_q <= hit_lvl_d;
      div_q     <= div_d;
      lvl_q     <= lvl_d;
      done_q    <= done_d;
      err_q     <= err_d;
    end
  end

  assign busy  = (st_q == S_SCAN);
  assign done  = done_q;
  assign err   = err_q;
  assign level = lvl_q;
  assign req_q = div_q;
endmodule

// File: rtl/dvfs_out_mux.sv
module dvfs_out_mux
  import dvfs_sel_pkg::*;
(
  input  lvl_cfg_t [NUM_LVL-1:0] cfg,
  input  logic                   en,
  input  logic [SRC_W-1:0]       st_src,
  input  logic [DIV_W-1:0]       st_div,
  input  logic [LVL_W-1:0]       level,
  output logic [SRC_W-1:0]       out_src,
  output logic [DIV_W-1:0]       out_div,
  output logic                   out_alt
);
  lvl_cfg_t cur;
  assign cur = cfg[level];

  always_comb begin
    if (en) begin
      out_src = cur.src;
      out_div = cur.div;
      out_alt = cur.alt;
    end else begin
      out_src = st_src;
      out_div = st_div;
      out_alt = 1'b0;
    end
  end
endmodule

// File: rtl/dvfs_level_sel.sv
module dvfs_level_sel
  import dvfs_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [2:0]        req_div,
  output logic              req_busy,
  output logic              req_done,
  output logic              req_err,
  output logic [1:0]        cur_level,
  output logic              dyn_on,
  output logic [1:0]        out_src,
  output logic [2:0]        out_div,
  output logic              out_alt
);
  logic                   rst_sync_n;
  lvl_cfg_t [NUM_LVL-1:0] cfg;
  logic                   en;
  logic [SRC_W-1:0]       st_src;
  logic [DIV_W-1:0]       st_div;
  logic [DIV_W-1:0]       req_div_q;

  dvfs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dvfs_cfg_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .cfg    (cfg),
    .en     (en),
    .st_src (st_src),
    .st_div (st_div)
  );

  dvfs_level_scan u_scan (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg       (cfg),
    .en        (en),
    .req_valid (req_valid),
    .req_div   (req_div),
    .busy      (req_busy),
    .done      (req_done),
    .err       (req_err),
    .level     (cur_level),
    .req_q     (req_div_q)
  );

  dvfs_out_mux u_mux (
    .cfg     (cfg),
    .en      (en),
    .st_src  (st_src),
    .st_div  (st_div),
    .level   (cur_level),
    .out_src (out_src),
    .out_div (out_div),
    .out_alt (out_alt)
  );

  assign dyn_on = en;
endmodule

// File: rtl/dvfs_level_sel_chk.sv
module dvfs_level_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [1:0] level,
  input logic       dyn_on,
  input logic [2:0] out_div,
  input logic [2:0] req_q
);
  logic [2:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 3'd1;
    else           busy_cnt <= '0;
  end

  a_r5_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == 3'd4);

  a_r5_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < 3'd4);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!done || err) |-> $stable(level));

  a_r8_disabled_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(dyn_on)) |-> err);

  a_r6_match_div: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && dyn_on) |-> out_div == req_q);

  a_r9_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(req_q));
endmodule

bind dvfs_level_sel dvfs_level_sel_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (req_busy),
  .done    (req_done),
  .err     (req_err),
  .level   (cur_level),
  .dyn_on  (dyn_on),
  .out_div (out_div),
  .req_q   (req_div_q)
);

// File: tb/dvfs_level_sel_tb.sv
module dvfs_level_sel_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [2:0]  req_div;
  logic        req_busy, req_done, req_err, dyn_on, out_alt;
  logic [1:0]  cur_level, out_src;
  logic [2:0]  out_div;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_div [4];
  int m_src [4];
  int m_alt [4];
  int m_en, m_st_src, m_st_div, m_level;

  dvfs_level_sel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_div(req_div),
    .req_busy(req_busy), .req_done(req_done), .req_err(req_err),
    .cur_level(cur_level), .dyn_on(dyn_on), .out_src(out_src),
    .out_div(out_div), .out_alt(out_alt)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_half(input int l);
    // junk in bits 12 and 8:0 must not matter (R4)
    return 16'((m_div[l] << 13) | (m_alt[l] << 11) | (m_src[l] << 9) | 16'h11FF);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic check_outputs(input string tag);
    if (m_en != 0) begin
      chk({tag, " R3 src"}, int'(out_src), m_src[m_level]);
      chk({tag, " R4 div"}, int'(out_div), m_div[m_level]);
      chk({tag, " R4 alt"}, int'(out_alt), m_alt[m_level]);
    end else begin
      chk({tag, " R2 src"}, int'(out_src), m_st_src);
      chk({tag, " R2 div"}, int'(out_div), m_st_div);
      chk({tag, " R2 alt"}, int'(out_alt), 0);
    end
    chk({tag, " level"}, int'(cur_level), m_level);
  endtask

  task automatic load_table(input int c);
    for (int l = 0; l < 4; l++) begin
      case (c)
        0: m_div[l] = l + 1;
        1: m_div[l] = (l == 0 || l == 2) ? 2 : (l == 1 ? 5 : 6);
        default: m_div[l] = (l == 0) ? 7 : (l == 3 ? 0 : 3);
      endcase
      m_src[l] = (l + c) % 4;
      m_alt[l] = (l + c) % 2;
    end
    wr(2'd0, {mk_half(0), mk_half(1)});
    wr(2'd1, {mk_half(2), mk_half(3)});
  endtask

  task automatic set_mode(input int en, input int s, input int d);
    m_en = en; m_st_src = s; m_st_div = d;
    wr(2'd2, (32'(en) << 31) | (32'(d) << 2) | 32'(s));
  endtask

  task automatic do_req(input int d, input bit inject, input int inj_div);
    int exp_lvl;
    bit exp_err;
    exp_lvl = -1;
    for (int l = 3; l >= 0; l--) if (m_div[l] == d) exp_lvl = l;
    exp_err = (m_en == 0) || (exp_lvl < 0);
    @(negedge clk);
    req_valid = 1; req_div = 3'(d);
    @(negedge clk);
    req_valid = 0;
    chk("R5 busy rises", int'(req_busy), 1);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      if (inject && k == 1) begin req_valid = 1; req_div = 3'(inj_div); end
      if (k == 2) req_valid = 0;
      chk("R5 busy held", int'(req_busy), 1);
      chk("R5 no early done", int'(req_done), 0);
    end
    @(negedge clk);
    req_valid = 0;
    chk("R5 busy falls", int'(req_busy), 0);
    chk("R5 done", int'(req_done), 1);
    if (exp_err) begin
      chk(m_en == 0 ? "R8 err" : "R7 err", int'(req_err), 1);
    end else begin
      chk("R6 no err", int'(req_err), 0);
      m_level = exp_lvl;
    end
    chk(exp_err ? "R7 level kept" : "R6 first match", int'(cur_level), m_level);
    check_outputs("after req");
    @(negedge clk);
    chk("R5 done pulse", int'(req_done), 0);
    chk("R7 err pulse", int'(req_err), 0);
    chk("R9 no second scan", int'(req_busy), 0);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    req_valid = 0; req_div = 0;
    m_en = 0; m_st_src = 0; m_st_div = 0; m_level = 0;
    for (int l = 0; l < 4; l++) begin m_div[l] = 0; m_src[l] = 0; m_alt[l] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(cur_level), 0);
    chk("R1 busy", int'(req_busy), 0);
    chk("R1 done", int'(req_done), 0);
    chk("R1 err", int'(req_err), 0);
    chk("R1 dyn_on", int'(dyn_on), 0);
    chk("R1 src", int'(out_src), 0);
    chk("R1 div", int'(out_div), 0);
    chk("R1 alt", int'(out_alt), 0);

    // R2 static selection for a sweep of static values
    for (int s = 0; s < 4; s++) begin
      set_mode(0, s, (s * 3 + 1) % 8);
      chk("R2 dyn_on", int'(dyn_on), 0);
      check_outputs("static");
    end

    // R3, R4, R6, R7: sweep every divider over three level tables
    for (int c = 0; c < 3; c++) begin
      load_table(c);
      set_mode(1, 1, 5);
      chk("R3 dyn_on", int'(dyn_on), 1);
      check_outputs("table");
      for (int d = 0; d < 8; d++) do_req(d, 0, 0);
      // visit every level explicitly (R3 mapping)
      for (int l = 3; l >= 0; l--) do_req(m_div[l], 0, 0);
    end

    // R8: disabled, request with a matching divider is rejected
    load_table(0);
    set_mode(1, 0, 0);
    do_req(3, 0, 0);
    set_mode(0, 2, 6);
    do_req(1, 0, 0);
    chk("R8 level kept", int'(cur_level), 2);
    set_mode(1, 2, 6);
    check_outputs("R8 reenable");

    // R9: request during busy is ignored
    do_req(4, 1, 1);
    chk("R9 captured divider wins", int'(cur_level), 3);
    do_req(2, 1, 7);

    // R10: write to address 3 changes nothing
    wr(2'd3, 32'hFFFF_FFFF);
    check_outputs("R10 enabled");
    chk("R10 dyn_on", int'(dyn_on), 1);
    set_mode(0, 3, 2);
    wr(2'd3, 32'h0000_0000);
    check_outputs("R10 static");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule